// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives an audio bit clock or master clock from a fast reference clock. The output can run at a rate that is not an integer fraction of the reference. Each output period lasts a whole number of reference cycles. An accumulator lengthens selected periods by one cycle, so that the long-run average ratio equals an integer part plus a fraction in 1/255 steps.

A single 32-bit control word is written through a simple write strobe and can always be read back. The word holds the following fields:

| Bits | Field |
|------|-------|
| 7:0 | fraction numerator F |
| 15:8 | fraction denominator D, normally 0xFF |
| 23:16 | integer field N |
| 24 | half-step select S |
| 25 | active-high stop bit |
| 28 | I2S mode bit |

The block drives two outputs. `clk_en` is a one-cycle strobe at the start of every output period. `clk_out` is a square wave with a duty cycle as close to one half as the period allows.

Top module: `audio_frac_div`

## Requirements
- R1: After reset, `reg_rdata` reads 0x1200FF00. The block resets stopped, with D = 0xFF and the mode bit set. Any write lands in the register one cycle later, and the raw written value is always read back unchanged, including illegal settings.
- R2: With F = 0, every output period is exactly 2·N + S reference cycles long, with N in bits 23:16 and S in bit 24.
- R3: With D = 0xFF, any 255 consecutive periods after a start sum to exactly 255·(2·N + S) + F reference cycles. A period is stretched by one cycle whenever the accumulator plus F reaches D, and the remainder is kept.
- R4: While bit 25 is 1, `clk_out` and `clk_en` are both held at 0, starting in the cycle the register holds the set bit. The fraction accumulator is cleared.
- R5: A period of length L starts with `clk_en` high and `clk_out` high. `clk_out` stays high for floor(L/2) cycles and is low for the remaining cycles.
- R6: A base ratio 2·N + S below 2 (N = 0) is treated as a ratio of 2.
- R7: A new divider value written mid-period does not change the current period. It governs periods starting from the next boundary.
- R8: Bit 28 has no effect on the output timing.
- R9: Clearing bit 25 starts a fresh period from count zero, with the accumulator starting from zero. The stretch pattern after a restart is the same as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current raw control word |
| clk_en | output | 1 | One-cycle strobe at each output period start |
| clk_out | output | 1 | Divided square-wave clock |

## Verification
The assertions check the following on every cycle:
- A write reaches the readback one cycle later, and the readback holds when no write occurs.
- Both outputs are silent whenever the stop bit reads back set.
- The start strobe never lasts two cycles, which would happen only below the clamped minimum ratio.
- Each period begins with the clock high.

Other properties span many periods, and only the bench scenarios can show them:
- Exact period lengths.
- The 255-period average.
- The high-phase width.
- Deferral of a mid-period write.
- Clearing of the accumulator across a stop and restart.

// File: rtl/afd_pkg.sv
package afd_pkg;
    localparam int FW       = 8;
    localparam int LW       = FW + 2;
    localparam int F_LSB    = 0;
    localparam int D_LSB    = 8;
    localparam int N_LSB    = 16;
    localparam int BIT_HALF = 24;
    localparam int BIT_OFF  = 25;
    localparam int BIT_MODE = 28;

    typedef struct packed {
        logic          off;
        logic [LW-1:0] base;
        logic [FW-1:0] num;
        logic [FW-1:0] den;
    } cfg_t;

    typedef struct packed {
        logic          run;
        logic [LW-1:0] cnt;
        logic [LW-1:0] len;
        logic [LW-1:0] half;
        logic [FW-1:0] acc;
    } per_t;
endpackage

// File: rtl/afd_cfg_decode.sv
module afd_cfg_decode
    import afd_pkg::*;
#(
    parameter int MIN_RATIO = 2
) (
    input  logic [BIT_OFF:0] ctrl,
    output cfg_t             cfg
);
    logic [LW-1:0] raw_ratio;

    always_comb begin
        raw_ratio = {1'b0, ctrl[N_LSB +: FW], 1'b0} + LW'(ctrl[BIT_HALF]);
        cfg.off   = ctrl[BIT_OFF];
        // R6: ratios below the minimum are clamped
        cfg.base  = (raw_ratio < LW'(MIN_RATIO)) ? LW'(MIN_RATIO) : raw_ratio;
        cfg.num   = ctrl[F_LSB +: FW];
        cfg.den   = ctrl[D_LSB +: FW];
    end
endmodule

// File: rtl/afd_frac_step.sv
module afd_frac_step
    import afd_pkg::*;
(
    input  logic [FW-1:0] acc,
    input  logic [FW-1:0] num,
    input  logic [FW-1:0] den,
    output logic [FW-1:0] acc_nxt,
    output logic          stretch
);
    logic [FW:0] sum;

    always_comb begin
        sum     = {1'b0, acc} + {1'b0, num};
        stretch = 1'b0;
        acc_nxt = sum[FW-1:0];
        if (den == '0) begin
            acc_nxt = '0;
        end else if (sum >= {1'b0, den}) begin
            // R3: carry out of the fraction lengthens this period
            stretch = 1'b1;
            acc_nxt = FW'(sum - {1'b0, den});
        end
    end
endmodule

// File: rtl/afd_period_gen.sv
module afd_period_gen
    import afd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    output logic strobe,
    output logic clk_o
);
    per_t          q, d;
    logic [FW-1:0] acc_nxt;
    logic          stretch;
    logic [LW-1:0] new_len;
    logic          at_end;

    afd_frac_step u_frac (
        .acc     (q.acc),
        .num     (cfg.num),
        .den     (cfg.den),
        .acc_nxt (acc_nxt),
        .stretch (stretch)
    );

    always_comb begin
        d       = q;
        new_len = cfg.base + LW'(stretch);
        at_end  = (q.cnt == q.len - LW'(1));
        if (cfg.off) begin
            // R4: stopped, accumulator cleared
            d.run = 1'b0;
            d.cnt = '0;
            d.acc = '0;
        end else if (!q.run || at_end) begin
            // R7, R9: configuration sampled only at a period start
            d.run  = 1'b1;
            d.cnt  = '0;
            d.len  = new_len;
            d.half = new_len >> 1;
            d.acc  = acc_nxt;
        end else begin
            d.cnt = q.cnt + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign strobe = q.run & ~cfg.off & (q.cnt == '0);
    assign clk_o  = q.run & ~cfg.off & (q.cnt < q.half);
endmodule

// File: rtl/audio_frac_div.sv
module audio_frac_div
    import afd_pkg::*;
#(
    parameter int            RW        = 32,
    parameter logic [RW-1:0] RESET_VAL = 32'h1200_FF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          clk_en,
    output logic          clk_out
);
    logic [RW-1:0] ctrl_d, ctrl_q;
    cfg_t          cfg;

    always_comb begin
        ctrl_d = reg_wr ? reg_wdata : ctrl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= RESET_VAL;
        else        ctrl_q <= ctrl_d;
    end

    afd_cfg_decode #(.MIN_RATIO(2)) u_dec (
        .ctrl (ctrl_q[BIT_OFF:0]),
        .cfg  (cfg)
    );

    afd_period_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .strobe (clk_en),
        .clk_o  (clk_out)
    );

    // R1, R8: raw word read back; mode bit only stored
    assign reg_rdata = ctrl_q;
endmodule

// File: rtl/afd_checker.sv
module afd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        clk_en,
    input logic        clk_out
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == $past(reg_wdata)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> $stable(reg_rdata)); // R1
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[25] |-> (!clk_en && !clk_out)); // R4
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !clk_en); // R6
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> clk_out); // R5
endmodule

bind audio_frac_div afd_checker u_afd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_en    (clk_en),
    .clk_out   (clk_out)
);

// File: tb/test_audio_frac_div.sv
module test_audio_frac_div;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // columns: N, S, F, expected cycles over 255 periods, label (0:R2 1:R3 2:R6)
    localparam int VEC [NV][5] = '{
        '{2,  0, 0,   1020,  0},
        '{3,  1, 0,   1785,  0},
        '{2,  1, 100, 1375,  1},
        '{10, 0, 255, 5355,  1},
        '{0,  0, 0,   510,   2},
        '{0,  1, 0,   510,   2},
        '{1,  0, 1,   511,   1},
        '{40, 1, 200, 20855, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;
    logic        clk_out;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_frac_div i_audio_frac_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_en    (clk_en),
        .clk_out   (clk_out)
    );

    function automatic logic [31:0] mk(bit mode, bit off, bit s, int n, int f);
        logic [7:0] nb = n[7:0];
        logic [7:0] fb = f[7:0];
        return {3'b000, mode, 2'b00, off, s, nb, 8'hFF, fb};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic next_strobe(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!clk_en && cyc < 4000);
    endtask

    task automatic restart(bit mode, bit s, int n, int f);
        wr(mk(mode, 1'b1, s, n, f));
        wr(mk(mode, 1'b0, s, n, f));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c, tot, hi, bad;
        string lab;

        // reset state (R1, R4)
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset value", int'(reg_rdata == 32'h1200_FF00), 1);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (clk_en || clk_out) bad++;
        end
        chk("R4 quiet after reset", bad, 0);

        // table walk: 255-period totals (R2, R3, R6)
        for (int v = 0; v < NV; v++) begin
            restart(1'b1, VEC[v][1][0], VEC[v][0], VEC[v][2]);
            chk("R1 readback", int'(reg_rdata == mk(1'b1, 1'b0, VEC[v][1][0], VEC[v][0], VEC[v][2])), 1);
            next_strobe(c);
            tot = 0;
            for (int k = 0; k < 255; k++) begin
                next_strobe(c);
                tot += c;
            end
            lab = (VEC[v][4] == 0) ? "R2 period total" :
                  (VEC[v][4] == 1) ? "R3 fractional total" : "R6 clamped total";
            chk(lab, tot, VEC[v][3]);
        end

        // R5: high phase width
        restart(1'b1, 1'b1, 2, 0);
        next_strobe(c);
        hi = 0;
        for (int i = 0; i < 5; i++) begin
            if (clk_out) hi++;
            @(negedge clk);
        end
        chk("R5 high cycles L=5", hi, 2);
        chk("R5 strobe at period start", int'(clk_en), 1);
        restart(1'b1, 1'b0, 2, 0);
        next_strobe(c);
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            if (clk_out) hi++;
            @(negedge clk);
        end
        chk("R5 high cycles L=4", hi, 2);

        // R7: mid-period write deferred
        restart(1'b1, 1'b0, 10, 0);
        next_strobe(c);
        repeat (3) @(negedge clk);
        wr(mk(1'b1, 1'b0, 1'b0, 2, 0));
        next_strobe(c);
        chk("R7 current period kept", c, 15);
        next_strobe(c);
        chk("R7 new period applied", c, 4);

        // R4: stop while running
        wr(mk(1'b1, 1'b1, 1'b0, 2, 0));
        chk("R4 stop bit readback", int'(reg_rdata[25]), 1);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (clk_en || clk_out) bad++;
            @(negedge clk);
        end
        chk("R4 outputs held low", bad, 0);

        // R9: accumulator restarts from zero
        wr(mk(1'b1, 1'b0, 1'b0, 2, 128));
        next_strobe(c);
        next_strobe(c);
        chk("R3 first period F=128", c, 4);
        next_strobe(c);
        chk("R3 second period F=128", c, 5);
        wr(mk(1'b1, 1'b1, 1'b0, 2, 128));
        wr(mk(1'b1, 1'b0, 1'b0, 2, 128));
        next_strobe(c);
        next_strobe(c);
        chk("R9 first period after restart", c, 4);
        next_strobe(c);
        chk("R9 second period after restart", c, 5);

        // R8: mode bit has no effect
        restart(1'b0, 1'b0, 3, 0);
        chk("R8 mode bit readback", int'(reg_rdata[28]), 0);
        next_strobe(c);
        next_strobe(c);
        chk("R8 period mode 0", c, 6);
        restart(1'b1, 1'b0, 3, 0);
        next_strobe(c);
        next_strobe(c);
        chk("R8 period mode 1", c, 6);

        // R1/R6: illegal value read back raw
        wr(mk(1'b1, 1'b0, 1'b0, 0, 0));
        chk("R6 raw illegal readback", int'(reg_rdata == 32'h1000_FF00), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule